// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data both ways between a narrow, fast port A of `W` bits and a wide, slower port B of `2*W` bits. Port B is split into two `W`-bit halves: the upper half (B1) and the lower half (B2). In the A-to-B direction, two A words arrive on successive clocks. Each is captured under its own active-low load strobe. The first word passes through two register stages and the second through one, so both show up on B at the same time as one wide word. In the B-to-A direction, each B half is captured in its own register. A select input then picks which captured half drives A.

Both drive enables are active low and registered, so the bus direction changes only at a clock edge. Each port is brought out as separate input data, output data and a drive-enable flag, and no tri-state wires are modelled. The data pins are sampled only by the load strobes. There is no valid/ready handshake and no back-pressure: a word that is on the pins at an edge whose strobe is high is simply not captured. All controls are plain level inputs. Reset is synchronous and active high.

Top module: `bus_xchg`

## Requirements
- R1: A clock edge with `rst`=1 clears every data register to zero and leaves `a_drive`=0 and `b_drive`=0.
- R2: The first A stage loads `a_din` at an edge where `a_cap1_n`=0. Otherwise it keeps its value.
- R3: At an edge where `a_cap2_n`=0, `b1_dout` takes the first-stage value from before that edge and `b2_dout` takes `a_din`. At an edge where `a_cap2_n`=1, both keep their values.
- R4: Word X captured with only `a_cap1_n`=0, followed on the next edge by word Y with only `a_cap2_n`=0, gives `b1_dout`=X and `b2_dout`=Y together after the second edge.
- R5: One word held on `a_din` with both A strobes low for two edges appears on `b1_dout` after the second edge, and on `b2_dout` after the first edge.
- R6: The B1 register loads `b1_din` when `b_cap1_n`=0, and the B2 register loads `b2_din` when `b_cap2_n`=0. The two load independently, and a register whose strobe is high keeps its value.
- R7: `a_dout` shows the B1 register when `b_sel`=1 and the B2 register when `b_sel`=0. It follows a change of `b_sel` with no clock edge needed.
- R8: After each edge, `a_drive` equals the inverse of `oea_n` at that edge and `b_drive` equals the inverse of `oeb_n` at that edge. The two are independent, so both, one or neither may be driving. Between edges they do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| oea_n | input | 1 | A-side drive request, active low, registered |
| oeb_n | input | 1 | B-side drive request, active low, registered |
| a_cap1_n | input | 1 | Load strobe for the first A stage, active low |
| a_cap2_n | input | 1 | Load strobe for the B1 output stage and B2 register, active low |
| b_cap1_n | input | 1 | Load strobe for the B1-to-A register, active low |
| b_cap2_n | input | 1 | Load strobe for the B2-to-A register, active low |
| b_sel | input | 1 | 1 selects the B1 register onto A, 0 selects B2 |
| a_din | input | W | Data arriving on port A |
| b1_din | input | W | Data arriving on the B1 half |
| b2_din | input | W | Data arriving on the B2 half |
| a_dout | output | W | Data driven onto port A |
| a_drive | output | 1 | A outputs active (0 = high impedance) |
| b1_dout | output | W | Data driven onto the B1 half |
| b2_dout | output | W | Data driven onto the B2 half |
| b_drive | output | 1 | B outputs active (0 = high impedance) |

## Verification
The bench walks through every combination of the four load strobes, both drive requests and the select line. On each step it feeds a data word that is a different arithmetic function of the step index. A word that shows up where it should not, or a stale word that stays, can then be traced to the strobe that was mishandled. A directed pairing sequence (X then Y) tells the two-stage B1 path from a one-stage path. Holding one word for two edges shows the two-edge latency. Toggling the select line between clock edges shows whether the A mux is combinational or wrongly registered.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  // Drive flags of both ports, carried as one small record.
  typedef struct packed {
    logic a;
    logic b;
  } drv_t;

  localparam int unsigned N_A2B_REGS = 3;
  localparam int unsigned N_B2A_REGS = 2;
endpackage

// File: rtl/xchg_en_reg.sv
module xchg_en_reg #(
  parameter int unsigned W       = 12,
  parameter logic        RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = {W{RST_BIT}};

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (!ld_n) q <= d;
  end
endmodule

// File: rtl/xchg_a2b.sv
module xchg_a2b #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap1_n,
  input  logic         cap2_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] b1_q,
  output logic [W-1:0] b2_q
);
  logic [W-1:0] stage1;

  // first word waits here
  xchg_en_reg #(.W(W)) u_stage1 (
    .clk(clk), .rst(rst), .ld_n(cap1_n), .d(din), .q(stage1));

  // second stage of the upper-half path
  xchg_en_reg #(.W(W)) u_stage2 (
    .clk(clk), .rst(rst), .ld_n(cap2_n), .d(stage1), .q(b1_q));

  // single stage of the lower-half path
  xchg_en_reg #(.W(W)) u_low (
    .clk(clk), .rst(rst), .ld_n(cap2_n), .d(din), .q(b2_q));
endmodule

// File: rtl/xchg_b2a.sv
module xchg_b2a #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap1_n,
  input  logic         cap2_n,
  input  logic         sel,
  input  logic [W-1:0] b1_din,
  input  logic [W-1:0] b2_din,
  output logic [W-1:0] a_q
);
  localparam int unsigned NH = xchg_pkg::N_B2A_REGS;

  logic [NH-1:0]       ld_n;
  logic [NH-1:0][W-1:0] din;
  logic [NH-1:0][W-1:0] held;

  assign ld_n = {cap1_n, cap2_n};
  assign din  = {b1_din, b2_din};

  for (genvar h = 0; h < NH; h++) begin : g_half
    xchg_en_reg #(.W(W)) u_hold (
      .clk(clk), .rst(rst), .ld_n(ld_n[h]), .d(din[h]), .q(held[h]));
  end

  // combinational select: index 1 is the upper half
  always_comb a_q = sel ? held[1] : held[0];
endmodule

// File: rtl/xchg_oe_sync.sv
module xchg_oe_sync (
  input  logic             clk,
  input  logic             rst,
  input  logic             oea_n,
  input  logic             oeb_n,
  output xchg_pkg::drv_t   drv
);
  logic [1:0] oe_q;

  // reset value 1 = both ports released
  xchg_en_reg #(.W(2), .RST_BIT(1'b1)) u_oe (
    .clk(clk), .rst(rst), .ld_n(1'b0), .d({oea_n, oeb_n}), .q(oe_q));

  always_comb begin
    drv.a = ~oe_q[1];
    drv.b = ~oe_q[0];
  end
endmodule

// File: rtl/bus_xchg.sv
module bus_xchg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oea_n,
  input  logic         oeb_n,
  input  logic         a_cap1_n,
  input  logic         a_cap2_n,
  input  logic         b_cap1_n,
  input  logic         b_cap2_n,
  input  logic         b_sel,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] b1_din,
  input  logic [W-1:0] b2_din,
  output logic [W-1:0] a_dout,
  output logic         a_drive,
  output logic [W-1:0] b1_dout,
  output logic [W-1:0] b2_dout,
  output logic         b_drive
);
  xchg_pkg::drv_t drv;

  xchg_a2b #(.W(W)) u_a2b (
    .clk(clk), .rst(rst), .cap1_n(a_cap1_n), .cap2_n(a_cap2_n),
    .din(a_din), .b1_q(b1_dout), .b2_q(b2_dout));

  xchg_b2a #(.W(W)) u_b2a (
    .clk(clk), .rst(rst), .cap1_n(b_cap1_n), .cap2_n(b_cap2_n),
    .sel(b_sel), .b1_din(b1_din), .b2_din(b2_din), .a_q(a_dout));

  xchg_oe_sync u_oe (
    .clk(clk), .rst(rst), .oea_n(oea_n), .oeb_n(oeb_n), .drv(drv));

  assign a_drive = drv.a;
  assign b_drive = drv.b;
endmodule

// File: rtl/bus_xchg_chk.sv
module bus_xchg_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         oea_n,
  input logic         oeb_n,
  input logic         a_cap1_n,
  input logic         a_cap2_n,
  input logic         b_cap1_n,
  input logic         b_cap2_n,
  input logic         b_sel,
  input logic [W-1:0] a_din,
  input logic [W-1:0] b1_din,
  input logic [W-1:0] b2_din,
  input logic [W-1:0] a_dout,
  input logic         a_drive,
  input logic [W-1:0] b1_dout,
  input logic [W-1:0] b2_dout,
  input logic         b_drive
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!a_drive && !b_drive && b1_dout == '0 && b2_dout == '0 && a_dout == '0));

  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    a_cap2_n |=> ($stable(b1_dout) && $stable(b2_dout)));

  // R3
  b2_load_chk: assert property (@(posedge clk) disable iff (rst)
    !a_cap2_n |=> (b2_dout == $past(a_din)));

  // R4
  pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_cap1_n ##1 !a_cap2_n) |=> (b1_dout == $past(a_din, 2)));

  // R7
  a_mux_chk: assert property (@(posedge clk) disable iff (rst)
    (!b_cap1_n && !b_cap2_n) |=> (a_dout == (b_sel ? $past(b1_din) : $past(b2_din))));

  // R8
  a_drive_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_drive == !$past(oea_n)));

  // R8
  b_drive_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (b_drive == !$past(oeb_n)));
endmodule

bind bus_xchg bus_xchg_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bus_xchg.sv
module sim_bus_xchg;
  localparam int W = 12;
  localparam logic [W-1:0] M = {W{1'b1}};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, oea_n = 1'b1, oeb_n = 1'b1;
  logic a_cap1_n = 1'b1, a_cap2_n = 1'b1, b_cap1_n = 1'b1, b_cap2_n = 1'b1, b_sel = 1'b0;
  logic [W-1:0] a_din = '0, b1_din = '0, b2_din = '0;
  logic [W-1:0] a_dout, b1_dout, b2_dout;
  logic a_drive, b_drive;

  bus_xchg #(.W(W)) u0 (.*);

  int total = 0, bad = 0;
  logic [W-1:0] m_st1, m_b1, m_b2, m_h1, m_h2;
  logic m_ad, m_bd;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // expected state after an edge, from the requirements
  task automatic model_edge;
    logic [W-1:0] old1;
    old1 = m_st1;
    if (!a_cap1_n) m_st1 = a_din;              // R2
    if (!a_cap2_n) begin m_b1 = old1; m_b2 = a_din; end // R3
    if (!b_cap1_n) m_h1 = b1_din;              // R6
    if (!b_cap2_n) m_h2 = b2_din;              // R6
    m_ad = !oea_n;                             // R8
    m_bd = !oeb_n;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick; tick;
    // R1 reset state
    check("R1 a_drive", a_drive, 0);
    check("R1 b_drive", b_drive, 0);
    check("R1 b1", b1_dout, 0);
    check("R1 b2", b2_dout, 0);
    check("R1 a", a_dout, 0);
    rst = 1'b0;
    m_st1 = '0; m_b1 = '0; m_b2 = '0; m_h1 = '0; m_h2 = '0; m_ad = 0; m_bd = 0;

    // sweep every control combination with arithmetic data
    for (int i = 0; i < 512; i++) begin
      a_cap1_n = i[0]; a_cap2_n = i[1]; b_cap1_n = i[2]; b_cap2_n = i[3];
      oea_n = i[4]; oeb_n = i[5]; b_sel = i[6];
      a_din  = W'((i * 37 + 5) & M);
      b1_din = W'((i * 113 + 9) & M);
      b2_din = W'((i * 71) ^ 12'h5a5);
      tick;
      model_edge();
      check("R2/R3 b1", b1_dout, m_b1);
      check("R3 b2", b2_dout, m_b2);
      check("R6/R7 a", a_dout, b_sel ? m_h1 : m_h2);
      check("R8 a_drive", a_drive, m_ad);
      check("R8 b_drive", b_drive, m_bd);
    end

    // R4 pairing X then Y
    a_cap1_n = 0; a_cap2_n = 1; a_din = 12'h3c1; tick;
    a_cap1_n = 1; a_cap2_n = 0; a_din = 12'hd72; tick;
    a_cap2_n = 1;
    check("R4 b1", b1_dout, 12'h3c1);
    check("R4 b2", b2_dout, 12'hd72);

    // R5 same word, both strobes low, two edges
    a_cap1_n = 0; a_cap2_n = 0; a_din = 12'h9e4; tick;
    check("R5 b2 first edge", b2_dout, 12'h9e4);
    check("R5 b1 not yet", b1_dout, 12'h3c1);
    tick;
    check("R5 b1 second edge", b1_dout, 12'h9e4);
    a_cap1_n = 1; a_cap2_n = 1;

    // R7 select change without an edge
    b_cap1_n = 0; b_cap2_n = 0; b1_din = 12'h111; b2_din = 12'h222; tick;
    b_cap1_n = 1; b_cap2_n = 1;
    b_sel = 1'b1; #1;
    check("R7 sel=1", a_dout, 12'h111);
    b_sel = 1'b0; #1;
    check("R7 sel=0", a_dout, 12'h222);

    // R8 drive flags do not move between edges
    oea_n = 0; oeb_n = 1; tick;
    oea_n = 1; oeb_n = 0; #2;
    check("R8 a held", a_drive, 1);
    check("R8 b held", b_drive, 0);
    tick;
    check("R8 a off", a_drive, 0);
    check("R8 b on", b_drive, 1);

    // R1 reset mid-run
    rst = 1'b1; tick; rst = 1'b0;
    check("R1 b1 cleared", b1_dout, 0);
    check("R1 a_drive cleared", a_drive, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule